// File: doc/BRIEF.md
# Sized Negate, Complement and OR Unit with Condition Flags

This block performs five integer operations on a destination operand at byte, word or long size: two's-complement negate, negate with extend, ones complement, inclusive OR, and OR with an immediate. It keeps a five-bit condition-flag register that each legal operation updates by its own rules. The result is formed combinationally in the same cycle as the request. Bits above the selected size are copied from the destination unchanged. The flags register is written on the clock edge where the request strobe is high.

Negate with extend also subtracts the stored extend flag. It only ever clears the zero flag, so a chain of these operations over a multi-word value leaves the zero flag showing whether the whole value came out zero. The caller must set the zero flag before the chain starts. Effective-address work, memory traffic and instruction fetch belong to the surrounding core.

Top module: `negor_alu`

## Requirements
- R1: `size` selects the operand width: 00 is byte (bits 7:0), 01 is word (bits 15:0) and 10 is long (bits 31:0). All arithmetic and the sign and zero tests use only those low bits. `result` bits above the width equal `dst`.
- R2: `op`=001 (negate) gives 0 − dst. Its flags are set as follows:
  - N is the sized result's top bit.
  - Z is 1 when the sized result is zero.
  - V is 1 only when dst is the most negative sized value.
  - C is 1 when the result is nonzero.
  - X equals C.
- R3: `op`=010 (negate with extend) gives 0 − dst − X. C and X both show the borrow out, which is 1 when the sized dst is nonzero or X was 1. N and V follow the rules of R2.
- R4: For negate with extend, Z is cleared when the sized result is nonzero and kept unchanged when it is zero.
- R5: `op`=011 (complement) gives the bitwise inverse of dst. N and Z follow the sized result, V and C become 0, and X is unchanged.
- R6: `op`=100 (OR) and `op`=101 (OR immediate) both give dst | src. N and Z follow the sized result, V and C become 0, and X is unchanged.
- R7: `op`=000 and the unused codes 110 and 111 are no-ops. `result` equals `dst` and no flag changes.
- R8: For an operation other than a no-op, `size`=11 is illegal. `err` is then high while `valid` is high, `result` equals `dst`, and the flags are not written.
- R9: `flags` is {X,N,Z,V,C}, with X in bit 4 and C in bit 0. It is written only on a clock edge with `valid` high. A synchronous reset clears all five bits to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| valid | input | 1 | Request strobe; enables the flag update |
| op | input | 3 | Operation code |
| size | input | 2 | Operand width code |
| dst | input | 32 | Destination operand |
| src | input | 32 | Source or immediate operand |
| result | output | 32 | Sized result merged with the untouched upper bits of dst |
| flags | output | 5 | Registered condition flags {X,N,Z,V,C} |
| err | output | 1 | Illegal width code on a real operation |

## Verification
Each negate is tried with three kinds of operand: zero, the most negative sized value, and an ordinary value. Only this set separates the carry rule from the overflow rule. Negate with extend runs as a chain with X and Z preset to each combination. This shows whether the borrow comes from X and whether Z is only ever cleared. The logical operations use operands that are zero only within the sized width, which exposes a zero test made over all 32 bits. Flags set just before each logical operation reveal any change to X.

// File: rtl/negor_alu.sv
module negor_alu (
  input  logic        clk,
  input  logic        rst,
  input  logic        valid,
  input  logic [2:0]  op,
  input  logic [1:0]  size,
  input  logic [31:0] dst,
  input  logic [31:0] src,
  output logic [31:0] result,
  output logic [4:0]  flags,
  output logic        err
);

  localparam logic [2:0] OP_NOP  = 3'd0;
  localparam logic [2:0] OP_NEG  = 3'd1;
  localparam logic [2:0] OP_NEGX = 3'd2;
  localparam logic [2:0] OP_NOT  = 3'd3;
  localparam logic [2:0] OP_OR   = 3'd4;
  localparam logic [2:0] OP_ORI  = 3'd5;
  localparam int FX = 4, FN = 3, FZ = 2, FV = 1, FC = 0;

  logic [31:0] mask, calc, sized;
  logic        x_in, r_msb, d_msb, zero, borrow, illegal, is_arith, is_logic, active;
  logic [4:0]  nxt;

  assign illegal  = (size == 2'b11);
  assign is_arith = (op == OP_NEG) || (op == OP_NEGX);
  assign is_logic = (op == OP_NOT) || (op == OP_OR) || (op == OP_ORI);
  assign active   = is_arith || is_logic;
  assign x_in     = (op == OP_NEGX) ? flags[FX] : 1'b0;

  always_comb begin
    case (size)
      2'b00:   begin mask = 32'h0000_00FF; r_msb = calc[7];  d_msb = dst[7];  end
      2'b01:   begin mask = 32'h0000_FFFF; r_msb = calc[15]; d_msb = dst[15]; end
      default: begin mask = 32'hFFFF_FFFF; r_msb = calc[31]; d_msb = dst[31]; end
    endcase
  end

  always_comb begin
    case (op)
      OP_NEG, OP_NEGX: calc = 32'd0 - dst - {31'd0, x_in};
      OP_NOT:          calc = ~dst;
      OP_OR, OP_ORI:   calc = dst | src;
      default:         calc = dst;
    endcase
  end

  assign sized  = calc & mask;
  assign zero   = (sized == 32'd0);
  assign borrow = ((dst & mask) != 32'd0) || x_in;
  assign result = illegal ? dst : ((dst & ~mask) | sized);
  assign err    = valid && active && illegal;

  always_comb begin
    nxt = flags;
    case (op)
      OP_NEG:  nxt = {borrow, r_msb, zero, d_msb & r_msb, borrow};
      OP_NEGX: nxt = {borrow, r_msb, flags[FZ] & zero, d_msb & r_msb, borrow};
      OP_NOT, OP_OR, OP_ORI: nxt = {flags[FX], r_msb, zero, 1'b0, 1'b0};
      default: nxt = flags;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)
      flags <= 5'd0;
    else if (valid && active && !illegal)
      flags <= nxt;
  end

  a_r1_upper_kept: assert property (@(posedge clk) disable iff (rst)
    (size == 2'b00) |-> (result[31:8] == dst[31:8]));

  a_r2_neg_carry: assert property (@(posedge clk) disable iff (rst)
    (valid && op == OP_NEG && !illegal) |=> (flags[FX] == flags[FC]) && (flags[FC] == !flags[FZ]));

  a_r4_z_sticky: assert property (@(posedge clk) disable iff (rst)
    (valid && op == OP_NEGX && !illegal && !flags[FZ]) |=> !flags[FZ]);

  a_r5_logic_vc: assert property (@(posedge clk) disable iff (rst)
    (valid && is_logic && !illegal) |=> (flags[1:0] == 2'b00) && (flags[FX] == $past(flags[FX])));

  a_r7_nop_stable: assert property (@(posedge clk) disable iff (rst)
    (valid && !active) |=> $stable(flags));

  a_r8_illegal_hold: assert property (@(posedge clk) disable iff (rst)
    (valid && active && illegal) |=> $stable(flags));

  a_r8_illegal_pass: assert property (@(posedge clk) disable iff (rst)
    (valid && active && illegal) |-> (err && result == dst));

  a_r9_idle_stable: assert property (@(posedge clk) disable iff (rst)
    !valid |=> $stable(flags));

endmodule

// File: tb/negor_alu_tb.sv
module negor_alu_tb;

  logic        clk = 1'b0;
  logic        rst, valid;
  logic [2:0]  op;
  logic [1:0]  size;
  logic [31:0] dst, src, result;
  logic [4:0]  flags;
  logic        err;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  negor_alu u_dut (.clk(clk), .rst(rst), .valid(valid), .op(op), .size(size),
                   .dst(dst), .src(src), .result(result), .flags(flags), .err(err));

  typedef struct packed {
    logic [2:0]  op;
    logic [1:0]  sz;
    logic [31:0] d;
    logic [31:0] s;
    logic [31:0] res;
    logic [4:0]  fl;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t TAB [NV] = '{
    '{3'd1, 2'd0, 32'h12345601, 32'h0, 32'h123456FF, 5'b11001}, // R2 R1 byte negate
    '{3'd1, 2'd1, 32'hAAAA8000, 32'h0, 32'hAAAA8000, 5'b11011}, // R2 word overflow
    '{3'd1, 2'd2, 32'h00000000, 32'h0, 32'h00000000, 5'b00100}, // R2 zero
    '{3'd3, 2'd0, 32'h000000F0, 32'h0, 32'h0000000F, 5'b00000}, // R5
    '{3'd4, 2'd1, 32'h11110000, 32'hFFFF0000, 32'h11110000, 5'b00100}, // R6 sized zero
    '{3'd5, 2'd2, 32'h80000000, 32'h00000001, 32'h80000001, 5'b01000}, // R6 ORI
    '{3'd1, 2'd0, 32'h00000002, 32'h0, 32'h000000FE, 5'b11001}, // R2
    '{3'd2, 2'd1, 32'h00000000, 32'h0, 32'h0000FFFF, 5'b11001}, // R3 X=1 borrow
    '{3'd0, 2'd2, 32'hDEADBEEF, 32'h0, 32'hDEADBEEF, 5'b11001}, // R7 nop
    '{3'd3, 2'd2, 32'hFFFFFFFF, 32'h0, 32'h00000000, 5'b10100}, // R5 keeps X
    '{3'd2, 2'd0, 32'h000000FF, 32'h0, 32'h00000000, 5'b10101}, // R3 R4 zero w/ borrow
    '{3'd2, 2'd0, 32'h00000000, 32'h0, 32'h000000FF, 5'b11001}, // R4 clears Z
    '{3'd1, 2'd2, 32'h00000000, 32'h0, 32'h00000000, 5'b00100}, // R2
    '{3'd2, 2'd1, 32'hABCD0000, 32'h0, 32'hABCD0000, 5'b00100}, // R4 keeps Z=1
    '{3'd5, 2'd0, 32'h00000000, 32'h00000041, 32'h00000041, 5'b00000}, // R6
    '{3'd2, 2'd0, 32'h00000000, 32'h0, 32'h00000000, 5'b00000}, // R4 Z stays 0
    '{3'd2, 2'd2, 32'h80000000, 32'h0, 32'h80000000, 5'b11011}  // R3 overflow
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic issue(input logic v, input logic [2:0] o, input logic [1:0] s,
                       input logic [31:0] d, input logic [31:0] sr);
    @(negedge clk);
    valid = v; op = o; size = s; dst = d; src = sr;
  endtask

  initial begin
    rst = 1'b1; valid = 1'b0; op = 3'd0; size = 2'd0; dst = 32'h0; src = 32'h0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R9 reset flags", {27'd0, flags}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      issue(1'b1, TAB[i].op, TAB[i].sz, TAB[i].d, TAB[i].s);
      #1;
      chk($sformatf("R1-vec%0d result", i), result, TAB[i].res);
      @(negedge clk);
      valid = 1'b0;
      chk($sformatf("R9-vec%0d flags", i), {27'd0, flags}, {27'd0, TAB[i].fl});
    end

    // R8 illegal width: err, pass-through, flags held at 11011
    issue(1'b1, 3'd1, 2'd3, 32'h12345678, 32'h0);
    #1;
    chk("R8 err", {31'd0, err}, 32'd1);
    chk("R8 result", result, 32'h12345678);
    @(negedge clk); valid = 1'b0;
    chk("R8 flags", {27'd0, flags}, 32'h1B);

    // R7 unused code 110 is a no-op, no err
    issue(1'b1, 3'd6, 2'd3, 32'h0000ABCD, 32'hFFFFFFFF);
    #1;
    chk("R7 result", result, 32'h0000ABCD);
    chk("R7 err", {31'd0, err}, 32'd0);
    @(negedge clk); valid = 1'b0;
    chk("R7 flags", {27'd0, flags}, 32'h1B);

    // R9 strobe low: no update
    issue(1'b0, 3'd3, 2'd2, 32'h0, 32'h0);
    @(negedge clk);
    chk("R9 idle flags", {27'd0, flags}, 32'h1B);

    // R9 reset mid-run
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R9 reset again", {27'd0, flags}, 32'd0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL R9 watchdog: got timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule